// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

The block is one channel of a DMA mover. Software fills a small register file with a 64-bit source address, a 64-bit destination address, a per-side mode (access width as a log2 byte count, and whether the address is held or stepped), a unit size in bytes, a unit count, and a pace value. Writing 1 to the control bit launches the channel. The engine then alternates read and write beats on a single memory port until it has moved unit size × unit count bytes. Between consecutive units it stays quiet for a programmed number of clocks.

Each beat moves 2^min(source width, destination width) bytes. A stepping address advances by that amount after every beat, and a held address repeats for the whole run, as a device FIFO would need. An end flag and an error flag latch in a flag register, and software clears them by writing 1 to them. The interrupt output is the OR of the flags that are enabled. Writing 0 to the control bit aborts a running transfer.

The controller has four states. S_IDLE waits for a launch. S_READ issues a read at the source address. S_WRITE writes the returned data at the destination address. S_GAP counts pace clocks between units. The transitions are as follows. Launch takes S_IDLE to S_READ, or sets the error flag and stays in S_IDLE if the configuration is bad. S_READ always goes to S_WRITE. S_WRITE goes to S_READ when beats remain in the unit, or when a new unit starts with a pace of zero. S_WRITE goes to S_GAP when a new unit starts with a nonzero pace. S_WRITE goes to S_IDLE after the final beat and sets the end flag. S_GAP goes to S_READ when its count runs out. An abort takes any busy state to S_IDLE.

Top module: `dmx_channel`

## Requirements
- R1: After reset, the status register reads 0, the flag register reads 0, irq is 0, and neither mem_rd nor mem_wr is asserted.
- R2: Registers sit at these byte offsets:
  - 0x08 pace: bits 5:0 request select, bits 23:16 idle clocks.
  - 0x10 source mode and 0x14 destination mode: bits 25:24 width code, where 0..3 mean 1, 2, 4, 8 bytes; bit 4 means hold.
  - 0x18 and 0x1C: upper halves of the source and destination addresses.
  - 0x20 and 0x24: lower halves of the source and destination addresses.
  - 0x28 unit size: bits 25:0. 0x2C unit count: bits 15:0.
  - 0x30 control: bit 0.
  - 0x34 enables: bit 0 end, bit 1 error.
  - 0x40 status: bit 0 busy.
  - 0x44 flags: bit 0 end, bit 1 error.
  - 0x48 enabled flags.

  Unused bits read 0.
- R3: Writing 1 to bit 0 of 0x30 while idle starts a transfer. Status bit 0 reads 1 from the next cycle until the transfer ends.
- R4: Each beat is a one-cycle read followed by a one-cycle write of the data returned one cycle after the read. A beat moves 2^min(source code, destination code) bytes, and mem_size carries that code. The transfer moves unit size × unit count bytes.
- R5: With hold clear, an address steps by the beat size after each beat. With hold set, the address stays at its programmed value for every beat.
- R6: Between the last write of one unit and the first read of the next, the port is idle for exactly the pace idle-clock count.
- R7: A launch with unit size 0, unit count 0, or a unit size that is not a multiple of the beat size sets flag bit 1, performs no memory access, and never shows busy.
- R8: Flag bit 0 sets in the same cycle that busy clears after the last beat of the last unit.
- R9: irq is 1 exactly when some flag bit and its enable bit are both 1, and 0x48 reads the AND of flags and enables.
- R10: Writing 1 to a bit of 0x44 clears that flag. Writing 0 leaves it as it was.
- R11: Writing 0 to bit 0 of 0x30 while busy stops the transfer. Busy reads 0 one cycle later, no further access takes place, and the end flag is not set.
- R12: While busy, writes to the pace, mode, address, size and count registers are ignored. Their readback and the running transfer are both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, OR of enabled flags |
| mem_rd | output | 1 | Memory read request, one beat |
| mem_wr | output | 1 | Memory write request, one beat |
| mem_addr | output | ADDR_W | Beat address |
| mem_size | output | 2 | Beat size as log2 bytes |
| mem_wdata | output | 64 | Write data, low bytes significant |
| mem_rdata | input | 64 | Read data, valid the cycle after mem_rd |

## Verification
The hardest state to reach from the ports is the one where the configuration registers are written in the middle of a run. Such a write must change neither the readback nor the data that lands in memory. The bench reaches it with a multi-unit transfer and a long pace, so it has a wide window in which to rewrite the source address and size. The final memory image then shows whether the write leaked into the run. The abort is also placed inside a long paced run, and the bench compares write counts before and after. The end-flag timing is checked by watching status and irq on every cycle as the last beat retires.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int REG_AW = 8;
    localparam logic [REG_AW-1:0] A_PACE     = 8'h08;
    localparam logic [REG_AW-1:0] A_SRC_MODE = 8'h10;
    localparam logic [REG_AW-1:0] A_DST_MODE = 8'h14;
    localparam logic [REG_AW-1:0] A_SRC_HI   = 8'h18;
    localparam logic [REG_AW-1:0] A_DST_HI   = 8'h1C;
    localparam logic [REG_AW-1:0] A_SRC_LO   = 8'h20;
    localparam logic [REG_AW-1:0] A_DST_LO   = 8'h24;
    localparam logic [REG_AW-1:0] A_USIZE    = 8'h28;
    localparam logic [REG_AW-1:0] A_UCOUNT   = 8'h2C;
    localparam logic [REG_AW-1:0] A_CTRL     = 8'h30;
    localparam logic [REG_AW-1:0] A_IRQ_EN   = 8'h34;
    localparam logic [REG_AW-1:0] A_STATUS   = 8'h40;
    localparam logic [REG_AW-1:0] A_FLAGS    = 8'h44;
    localparam logic [REG_AW-1:0] A_SEEN     = 8'h48;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_GAP   = 2'd3
    } dmx_state_e;
endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 26,
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int REQ_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              err_i,
    output logic              go_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [1:0]        src_lg_o,
    output logic [1:0]        dst_lg_o,
    output logic              src_fix_o,
    output logic              dst_fix_o,
    output logic [SIZE_W-1:0] usize_o,
    output logic [CNT_W-1:0]  ucnt_o,
    output logic [GAP_W-1:0]  gap_o,
    output logic              irq_o
);
    logic [REQ_W-1:0]  req_q;
    logic [GAP_W-1:0]  gap_q;
    logic [1:0]        slg_q, dlg_q, ien_q, flags_q;
    logic              sfix_q, dfix_q;
    logic [31:0]       shi_q, slo_q, dhi_q, dlo_q;
    logic [SIZE_W-1:0] usize_q;
    logic [CNT_W-1:0]  ucnt_q;
    logic              cfg_we;

    assign cfg_we = reg_wr && !busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0; gap_q <= '0; slg_q <= '0; dlg_q <= '0;
            sfix_q <= 1'b0; dfix_q <= 1'b0;
            shi_q <= '0; slo_q <= '0; dhi_q <= '0; dlo_q <= '0;
            usize_q <= '0; ucnt_q <= '0;
        end else if (cfg_we) begin
            unique case (reg_addr)
                A_PACE: begin
                    req_q <= reg_wdata[REQ_W-1:0];
                    gap_q <= reg_wdata[16 +: GAP_W];
                end
                A_SRC_MODE: begin slg_q <= reg_wdata[25:24]; sfix_q <= reg_wdata[4]; end
                A_DST_MODE: begin dlg_q <= reg_wdata[25:24]; dfix_q <= reg_wdata[4]; end
                A_SRC_HI: shi_q   <= reg_wdata;
                A_DST_HI: dhi_q   <= reg_wdata;
                A_SRC_LO: slo_q   <= reg_wdata;
                A_DST_LO: dlo_q   <= reg_wdata;
                A_USIZE:  usize_q <= reg_wdata[SIZE_W-1:0];
                A_UCOUNT: ucnt_q  <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q   <= '0;
            flags_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_IRQ_EN) ien_q <= reg_wdata[1:0];
            flags_q <= (flags_q & ~((reg_wr && reg_addr == A_FLAGS) ? reg_wdata[1:0] : 2'b00))
                     | {err_i, done_i};
        end
    end

    assign go_o   = reg_wr && reg_addr == A_CTRL && reg_wdata[0] && !busy_i;
    assign stop_o = reg_wr && reg_addr == A_CTRL && !reg_wdata[0] && busy_i;
    assign src_o  = ADDR_W'({shi_q, slo_q});
    assign dst_o  = ADDR_W'({dhi_q, dlo_q});
    assign src_lg_o = slg_q;  assign dst_lg_o = dlg_q;
    assign src_fix_o = sfix_q; assign dst_fix_o = dfix_q;
    assign usize_o = usize_q; assign ucnt_o = ucnt_q; assign gap_o = gap_q;
    assign irq_o   = |(flags_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_PACE:     begin reg_rdata[REQ_W-1:0] = req_q; reg_rdata[16 +: GAP_W] = gap_q; end
            A_SRC_MODE: begin reg_rdata[25:24] = slg_q; reg_rdata[4] = sfix_q; end
            A_DST_MODE: begin reg_rdata[25:24] = dlg_q; reg_rdata[4] = dfix_q; end
            A_SRC_HI:   reg_rdata = shi_q;
            A_DST_HI:   reg_rdata = dhi_q;
            A_SRC_LO:   reg_rdata = slo_q;
            A_DST_LO:   reg_rdata = dlo_q;
            A_USIZE:    reg_rdata[SIZE_W-1:0] = usize_q;
            A_UCOUNT:   reg_rdata[CNT_W-1:0] = ucnt_q;
            A_CTRL:     reg_rdata[0] = busy_i;
            A_IRQ_EN:   reg_rdata[1:0] = ien_q;
            A_STATUS:   reg_rdata[0] = busy_i;
            A_FLAGS:    reg_rdata[1:0] = flags_q;
            A_SEEN:     reg_rdata[1:0] = flags_q & ien_q;
            default:    reg_rdata = '0;
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(usize_q) && $stable(slo_q) && $stable(dlo_q)); // R12
    AST_END_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> $past(done_i)); // R8
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 26,
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [1:0]        src_lg_i,
    input  logic [1:0]        dst_lg_i,
    input  logic              src_fix_i,
    input  logic              dst_fix_i,
    input  logic [SIZE_W-1:0] usize_i,
    input  logic [CNT_W-1:0]  ucnt_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        mem_size_o,
    output logic [63:0]       mem_wdata_o,
    input  logic [63:0]       mem_rdata_i
);
    dmx_state_e        state_q, state_d;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [1:0]        lg_q, beat_lg;
    logic              sfix_q, dfix_q;
    logic [SIZE_W-1:0] bpu_q, beat_left, lo_mask;
    logic [CNT_W-1:0]  unit_left;
    logic [GAP_W-1:0]  gap_q, gap_cnt;
    logic              cfg_bad, launch, last_beat, last_unit;

    assign beat_lg   = (src_lg_i < dst_lg_i) ? src_lg_i : dst_lg_i;
    assign lo_mask   = (SIZE_W'(1) << beat_lg) - SIZE_W'(1);
    assign cfg_bad   = (usize_i == '0) || (ucnt_i == '0) || |(usize_i & lo_mask);
    assign launch    = go_i && (state_q == S_IDLE) && !cfg_bad;
    assign last_beat = (beat_left == '0);
    assign last_unit = (unit_left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch) state_d = S_READ;
            S_READ:  state_d = stop_i ? S_IDLE : S_WRITE;
            S_WRITE: begin
                if (stop_i)                  state_d = S_IDLE;
                else if (!last_beat)         state_d = S_READ;
                else if (last_unit)          state_d = S_IDLE;
                else if (gap_q == '0)        state_d = S_READ;
                else                         state_d = S_GAP;
            end
            S_GAP:   begin
                if (stop_i)                  state_d = S_IDLE;
                else if (gap_cnt <= GAP_W'(1)) state_d = S_READ;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; lg_q <= '0; sfix_q <= 1'b0; dfix_q <= 1'b0;
            bpu_q <= '0; beat_left <= '0; unit_left <= '0; gap_q <= '0; gap_cnt <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (launch) begin
                    src_q     <= src_i;
                    dst_q     <= dst_i;
                    lg_q      <= beat_lg;
                    sfix_q    <= src_fix_i;
                    dfix_q    <= dst_fix_i;
                    bpu_q     <= usize_i >> beat_lg;
                    beat_left <= (usize_i >> beat_lg) - SIZE_W'(1);
                    unit_left <= ucnt_i - CNT_W'(1);
                    gap_q     <= gap_i;
                end
                S_WRITE: begin
                    if (!sfix_q) src_q <= src_q + (ADDR_W'(1) << lg_q);
                    if (!dfix_q) dst_q <= dst_q + (ADDR_W'(1) << lg_q);
                    if (!last_beat) begin
                        beat_left <= beat_left - SIZE_W'(1);
                    end else if (!last_unit) begin
                        beat_left <= bpu_q - SIZE_W'(1);
                        unit_left <= unit_left - CNT_W'(1);
                        gap_cnt   <= gap_q;
                    end
                end
                S_GAP:   gap_cnt <= gap_cnt - GAP_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o      = (state_q != S_IDLE);
        mem_rd_o    = (state_q == S_READ);
        mem_wr_o    = (state_q == S_WRITE);
        mem_addr_o  = (state_q == S_WRITE) ? dst_q : src_q;
        mem_size_o  = lg_q;
        mem_wdata_o = mem_rdata_i;
        done_o      = (state_q == S_WRITE) && !stop_i && last_beat && last_unit;
        err_o       = go_i && (state_q == S_IDLE) && cfg_bad;
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> $past(mem_rd_o)); // R4
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && busy_o) |=> !busy_o && !mem_rd_o && !mem_wr_o); // R11
    AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !busy_o); // R7
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o && !mem_rd_o); // R8
    AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && sfix_q && $past(mem_wr_o)) |-> mem_addr_o == $past(mem_addr_o, 2)); // R5
endmodule

// File: rtl/dmx_channel.sv
module dmx_channel
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 26,
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata
);
    logic              busy, done, err, go, stop, sfix, dfix;
    logic [ADDR_W-1:0] src, dst;
    logic [1:0]        slg, dlg;
    logic [SIZE_W-1:0] usize;
    logic [CNT_W-1:0]  ucnt;
    logic [GAP_W-1:0]  gap;

    dmx_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .done_i(done), .err_i(err), .go_o(go), .stop_o(stop),
        .src_o(src), .dst_o(dst), .src_lg_o(slg), .dst_lg_o(dlg),
        .src_fix_o(sfix), .dst_fix_o(dfix), .usize_o(usize), .ucnt_o(ucnt),
        .gap_o(gap), .irq_o(irq)
    );

    dmx_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go_i(go), .stop_i(stop),
        .src_i(src), .dst_i(dst), .src_lg_i(slg), .dst_lg_i(dlg),
        .src_fix_i(sfix), .dst_fix_i(dfix), .usize_i(usize), .ucnt_i(ucnt),
        .gap_i(gap), .busy_o(busy), .done_o(done), .err_o(err),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );
endmodule

// File: tb/dmx_channel_bench.sv
`timescale 1ns/1ps
module dmx_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_rd, mem_wr;
    logic [63:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [63:0] mem_rdata = '0;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dmx_channel u_dmx_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [0:1023];
    int  cyc = 0, n_rd = 0, n_wr = 0, first_rd = -1, last_wr = -1;
    bit  mon_clr = 0, fix_bad = 0, watch_fix = 0;
    logic [63:0] fix_addr = '0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (mem_rd) begin
            for (int k = 0; k < 8; k++)
                mem_rdata[8*k +: 8] <= (k < (1 << mem_size)) ? mem[(mem_addr[9:0] + k) & 1023] : 8'h00;
        end
        if (mem_wr) begin
            for (int k = 0; k < 8; k++)
                if (k < (1 << mem_size)) mem[(mem_addr[9:0] + k) & 1023] = mem_wdata[8*k +: 8];
        end
        if (mon_clr) begin
            n_rd = 0; n_wr = 0; first_rd = -1; last_wr = -1; fix_bad = 0;
        end else begin
            if (mem_rd) begin
                n_rd++;
                if (first_rd < 0) first_rd = cyc;
                if (watch_fix && mem_addr != fix_addr) fix_bad = 1;
            end
            if (mem_wr) begin n_wr++; last_wr = cyc; end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        @(negedge clk); mon_clr = 1; @(negedge clk); mon_clr = 0;
    endtask

    task automatic setup(input int s, input int d, input int slg, input int dlg,
                         input bit sf, input bit df, input int sz, input int cnt, input int gap);
        wr(8'h20, s); wr(8'h18, 0); wr(8'h24, d); wr(8'h1C, 0);
        wr(8'h10, (slg << 24) | (sf << 4));
        wr(8'h14, (dlg << 24) | (df << 4));
        wr(8'h28, sz); wr(8'h2C, cnt); wr(8'h08, gap << 16);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(8'h40, v);
            if (!v[0]) break;
        end
    endtask

    task automatic clear_flags();
        wr(8'h44, 3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h40, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h44, v); chk(v == 0, "R1 flags", v, 0);
        chk(!irq && !mem_rd && !mem_wr, "R1 outputs", {irq, mem_rd, mem_wr}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk(v == 32'h0300_0010, "R2 src mode", v, 32'h0300_0010);
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk(v == 32'h03FF_FFFF, "R2 unit size", v, 32'h03FF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); chk(v == 32'h0000_FFFF, "R2 unit count", v, 32'hFFFF);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk(v == 32'h00FF_003F, "R2 pace", v, 32'h00FF_003F);
        wr(8'h1C, 32'h1234_5678); rd(8'h1C, v); chk(v == 32'h1234_5678, "R2 dst upper", v, 32'h1234_5678);
    endtask

    task automatic t_copy();
        logic [31:0] v;
        bit ok = 1;
        init_mem();
        setup(32'h100, 32'h200, 2, 2, 0, 0, 8, 3, 0);
        wr(8'h30, 1);
        rd(8'h40, v); chk(v[0] == 1, "R3 busy after start", v, 1);
        wait_idle();
        for (int i = 0; i < 24; i++) if (mem[32'h200 + i] != pat(32'h100 + i)) ok = 0;
        chk(ok, "R4 copied 24 bytes", ok, 1);
        chk(mem[32'h218] == pat(32'h218), "R4 byte past end untouched", mem[32'h218], pat(32'h218));
        chk(n_wr == 6, "R4 beat count 4-byte", n_wr, 6);
        chk(last_wr - first_rd == 11, "R6 no idle with zero pace", last_wr - first_rd, 11);
        clear_flags();
    endtask

    task automatic t_mixed();
        bit ok = 1;
        init_mem();
        setup(32'h140, 32'h240, 3, 0, 0, 0, 4, 2, 0);
        wr(8'h30, 1);
        wait_idle();
        chk(n_wr == 8, "R4 narrower side sets beat", n_wr, 8);
        for (int i = 0; i < 8; i++) if (mem[32'h240 + i] != pat(32'h140 + i)) ok = 0;
        chk(ok, "R4 bytewise copy", ok, 1);
        clear_flags();
    endtask

    task automatic t_fixed();
        bit ok = 1;
        init_mem();
        fix_addr = 64'h40; watch_fix = 1;
        setup(32'h40, 32'h280, 2, 2, 1, 0, 4, 3, 0);
        wr(8'h30, 1);
        wait_idle();
        watch_fix = 0;
        chk(!fix_bad && n_rd == 3, "R5 held source address", n_rd, 3);
        for (int i = 0; i < 12; i++) if (mem[32'h280 + i] != pat(32'h40 + (i % 4))) ok = 0;
        chk(ok, "R5 stepping destination", ok, 1);
        clear_flags();
        init_mem();
        setup(32'h100, 32'h300, 2, 2, 0, 1, 4, 3, 0);
        wr(8'h30, 1);
        wait_idle();
        ok = 1;
        for (int i = 0; i < 4; i++) if (mem[32'h300 + i] != pat(32'h108 + i)) ok = 0;
        chk(ok, "R5 held destination holds last word", ok, 1);
        chk(mem[32'h304] == pat(32'h304), "R5 held destination no spill", mem[32'h304], pat(32'h304));
        clear_flags();
    endtask

    task automatic t_pace();
        init_mem();
        setup(32'h100, 32'h200, 2, 2, 0, 0, 4, 3, 5);
        wr(8'h30, 1);
        wait_idle();
        chk(last_wr - first_rd == 15, "R6 idle clocks between units", last_wr - first_rd, 15);
        chk(n_rd == 3 && n_wr == 3, "R6 access count", n_wr, 3);
        clear_flags();
    endtask

    task automatic t_errors();
        logic [31:0] v;
        int szs [3] = '{0, 4, 6};
        int cnts[3] = '{2, 0, 2};
        for (int k = 0; k < 3; k++) begin
            init_mem();
            setup(32'h100, 32'h200, 2, 2, 0, 0, szs[k], cnts[k], 0);
            wr(8'h30, 1);
            rd(8'h40, v); chk(v == 0, "R7 never busy", v, 0);
            rd(8'h44, v); chk(v == 2, "R7 error flag", v, 2);
            chk(n_rd == 0 && n_wr == 0, "R7 no access", n_rd + n_wr, 0);
            wr(8'h44, 2); rd(8'h44, v); chk(v == 0, "R10 error cleared", v, 0);
        end
    endtask

    task automatic t_end_irq();
        logic [31:0] v;
        bit prev_irq = 0, seen = 0;
        init_mem();
        wr(8'h34, 1);
        setup(32'h100, 32'h200, 2, 2, 0, 0, 8, 2, 3);
        wr(8'h30, 1);
        @(negedge clk); reg_addr = 8'h40;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (!reg_rdata[0]) begin
                chk(irq && !prev_irq, "R8 end flag with busy fall", {irq, prev_irq}, 2'b10);
                seen = 1;
                break;
            end
            prev_irq = irq;
        end
        chk(seen, "R8 transfer finished", seen, 1);
        rd(8'h48, v); chk(v == 1, "R9 enabled flags", v, 1);
        wr(8'h34, 0);
        @(negedge clk); #1 chk(!irq, "R9 masked irq", irq, 0);
        rd(8'h44, v); chk(v == 1, "R9 flag kept while masked", v, 1);
        wr(8'h44, 2); rd(8'h44, v); chk(v == 1, "R10 other bit untouched", v, 1);
        wr(8'h44, 1); rd(8'h44, v); chk(v == 0, "R10 end cleared", v, 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int w0;
        init_mem();
        setup(32'h100, 32'h200, 2, 2, 0, 0, 4, 50, 10);
        wr(8'h30, 1);
        repeat (8) @(negedge clk);
        wr(8'h30, 0);
        #1 chk(reg_rdata[0] == 0 || reg_addr != 8'h40, "R11 pre", 0, 0);
        rd(8'h40, v); chk(v == 0, "R11 busy cleared", v, 0);
        w0 = n_wr;
        repeat (40) @(negedge clk);
        chk(n_wr == w0, "R11 no more access", n_wr, w0);
        rd(8'h44, v); chk(v == 0, "R11 no end flag", v, 0);
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        bit ok = 1;
        init_mem();
        setup(32'h100, 32'h200, 2, 2, 0, 0, 4, 4, 20);
        wr(8'h30, 1);
        wr(8'h20, 32'h380);
        wr(8'h28, 32'h10);
        rd(8'h20, v); chk(v == 32'h100, "R12 source readback kept", v, 32'h100);
        rd(8'h28, v); chk(v == 4, "R12 size readback kept", v, 4);
        wait_idle();
        for (int i = 0; i < 16; i++) if (mem[32'h200 + i] != pat(32'h100 + i)) ok = 0;
        chk(ok && n_wr == 4, "R12 transfer unchanged", n_wr, 4);
        clear_flags();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_copy();
        t_mixed();
        t_fixed();
        t_pace();
        t_errors();
        t_end_irq();
        t_stop();
        t_busy_writes();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule